// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Combiner

This block watches a set of general-purpose pins, grouped into banks of equal width (four banks of 32 pins by default), and records selected transitions in per-bank sticky status vectors. Each pin has three controls: a direction bit, a rising-edge enable and a falling-edge enable. A pin set up as an output never records an event. Software clears recorded events one bank at a time by writing ones to the bits it wants cleared.

The status vectors drive three registered, level-sensitive interrupt lines. Bank 0 bit 0 has its own line. Bank 0 bit 1 has its own line. Every other status bit, in every bank, is ORed onto a third shared line. While the processor reports that it is halted, a transition on an input pin that belongs to a fixed per-bank wake mask produces a one-cycle wake pulse.

Pin levels are taken to be already synchronized. The control vectors and the clear strobes are plain levels sampled on each clock, so the edge of the block carries no stream handshake and exerts no back-pressure.

Top module: `gpio_edge_irq`

## Requirements
- R1: When a pin samples 1 after sampling 0 on the previous clock, its status bit (flat index bank*32+bit) is set on that clock edge, provided its rising enable is 1 and its direction bit is 0 (input).
- R2: When a pin samples 0 after sampling 1 on the previous clock, its status bit is set on that clock edge, provided its falling enable is 1 and its direction bit is 0.
- R3: Status bits stay set until cleared. In a cycle where `clr_bank_we[b]` is 1, each bit of bank b whose `clr_data` bit is 1 is cleared. Bits whose `clr_data` bit is 0 are left unchanged, and so are banks whose strobe is 0.
- R4: `irq_pin0` equals bank 0 status bit 0, and `irq_pin1` equals bank 0 status bit 1. Each line is one clock later than the status it follows.
- R5: `irq_shared` is the OR of bank 0 status bits 31..2 and all status bits of banks 1 to 3. It is one clock later than that status.
- R6: While `halted` is 1, a transition in either direction on an input pin that is in the wake mask makes `wake_pulse` 1 for exactly one cycle, one clock after the edge is sampled. The edge enables play no part in this. The wake masks for banks 0 to 3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F.
- R7: No wake pulse is produced when `halted` is 0, or when the pin is outside the wake mask.
- R8: A pin whose direction bit is 1 (output) never sets a status bit and never causes a wake pulse.
- R9: If an edge sets a bit in the same cycle that the bit is being cleared, the bit ends up set.
- R10: The first pin sample after reset only loads the history register, so pins that are already high when reset is released record no edge.
- R11: During reset, all status bits, the three interrupt lines and `wake_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_level | input | 128 | Synchronized pin levels, index bank*32+bit |
| pin_is_out | input | 128 | Direction per pin, 1 = output |
| rise_en | input | 128 | Rising-edge enable per pin |
| fall_en | input | 128 | Falling-edge enable per pin |
| clr_bank_we | input | 4 | Per-bank write-one-to-clear strobe |
| clr_data | input | 32 | Bits to clear in each strobed bank |
| halted | input | 1 | Processor is halted |
| edge_status | output | 128 | Sticky status, index bank*32+bit |
| irq_pin0 | output | 1 | Interrupt for bank 0 bit 0 |
| irq_pin1 | output | 1 | Interrupt for bank 0 bit 1 |
| irq_shared | output | 1 | Interrupt for all other status bits |
| wake_pulse | output | 1 | One-cycle wake request |

## Verification
The bench targets the uneven interrupt split: it places single events on bank 0 bits 0, 1 and 2 and in higher banks, so a design with a shifted shared-line range would raise the wrong line. It drives wake candidates inside and outside the mask with `halted` both high and low, so a design that ignores the mask or the halted flag would pulse when it should stay quiet. It also holds the pins high through reset, which would expose a design that reports a spurious rising edge on the first sample. Finally, it clears bits with zero data, with the wrong bank strobe, and in the same cycle as a new edge; a design whose clear path wins would lose that event.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned MASK_W = 32;

  // Fixed per-bank wake eligibility; banks past 3 are not eligible.
  function automatic logic [MASK_W-1:0] wake_mask(input int unsigned bank);
    case (bank)
      0:       wake_mask = 32'h8003_FE1B;
      1:       wake_mask = 32'h0020_01FC;
      2:       wake_mask = 32'hEC08_0000;
      3:       wake_mask = 32'h0012_007F;
      default: wake_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int unsigned BANK_W = 32,
  parameter logic [BANK_W-1:0] WAKE_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              primed,
  input  logic [BANK_W-1:0] pin,
  input  logic [BANK_W-1:0] is_out,
  input  logic [BANK_W-1:0] rise,
  input  logic [BANK_W-1:0] fall,
  input  logic              clr_we,
  input  logic [BANK_W-1:0] clr_bits,
  output logic [BANK_W-1:0] status,
  output logic              wake_hit
);
  logic [BANK_W-1:0] prev_q;
  logic [BANK_W-1:0] status_q;
  logic [BANK_W-1:0] rose, fell, set_v, clr_v, in_mask;

  always_comb begin
    in_mask = ~is_out & {BANK_W{primed}};
    rose    = pin & ~prev_q & in_mask;
    fell    = ~pin & prev_q & in_mask;
    set_v   = (rose & rise) | (fell & fall);
    clr_v   = clr_we ? clr_bits : '0;
    // one or more eligible input pins toggled this clock
    wake_hit = |((rose | fell) & WAKE_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= pin;
      // the set term is ORed last so a new edge survives a clear
      status_q <= (status_q & ~clr_v) | set_v;
    end
  end

  assign status = status_q;

  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
  parameter int unsigned TOTAL_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TOTAL_W-1:0] status,
  output logic               irq0,
  output logic               irq1,
  output logic               irq_rest
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq0     <= 1'b0;
      irq1     <= 1'b0;
      irq_rest <= 1'b0;
    end else begin
      irq0     <= status[0];
      irq1     <= status[1];
      irq_rest <= |status[TOTAL_W-1:2];
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 32,
  localparam int unsigned TOTAL_W  = NUM_BANKS * BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TOTAL_W-1:0]   pin_level,
  input  logic [TOTAL_W-1:0]   pin_is_out,
  input  logic [TOTAL_W-1:0]   rise_en,
  input  logic [TOTAL_W-1:0]   fall_en,
  input  logic [NUM_BANKS-1:0] clr_bank_we,
  input  logic [BANK_W-1:0]    clr_data,
  input  logic                 halted,
  output logic [TOTAL_W-1:0]   edge_status,
  output logic                 irq_pin0,
  output logic                 irq_pin1,
  output logic                 irq_shared,
  output logic                 wake_pulse
);
  logic                 primed_q;
  logic                 wake_q;
  logic [NUM_BANKS-1:0] bank_wake;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      wake_q   <= halted & (|bank_wake);
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    gpio_edge_bank #(
      .BANK_W    (BANK_W),
      .WAKE_MASK (BANK_W'(gpio_edge_pkg::wake_mask(g)))
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .primed   (primed_q),
      .pin      (pin_level[g*BANK_W +: BANK_W]),
      .is_out   (pin_is_out[g*BANK_W +: BANK_W]),
      .rise     (rise_en[g*BANK_W +: BANK_W]),
      .fall     (fall_en[g*BANK_W +: BANK_W]),
      .clr_we   (clr_bank_we[g]),
      .clr_bits (clr_data),
      .status   (edge_status[g*BANK_W +: BANK_W]),
      .wake_hit (bank_wake[g])
    );
  end

  gpio_irq_combine #(.TOTAL_W(TOTAL_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .status   (edge_status),
    .irq0     (irq_pin0),
    .irq1     (irq_pin1),
    .irq_rest (irq_shared)
  );

  assign wake_pulse = wake_q;

  // R8
  out_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_status & ~$past(edge_status) & $past(pin_is_out)) == '0));

  // R6
  wake_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(halted));

  // R4
  irq0_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin0 == $past(edge_status[0]));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!rst_n -> (edge_status == '0 && !wake_pulse)));
endmodule

// File: tb/gpio_edge_irq_bench.sv
module gpio_edge_irq_bench;
  localparam int NB = 4;
  localparam int BW = 32;
  localparam int TW = NB * BW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] pin_level = '0, pin_is_out = '0, rise_en = '0, fall_en = '0;
  logic [NB-1:0] clr_bank_we = '0;
  logic [BW-1:0] clr_data = '0;
  logic halted = 1'b0;
  logic [TW-1:0] edge_status;
  logic irq_pin0, irq_pin1, irq_shared, wake_pulse;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_edge_irq u_gpio_edge_irq (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .pin_is_out(pin_is_out),
    .rise_en(rise_en), .fall_en(fall_en), .clr_bank_we(clr_bank_we),
    .clr_data(clr_data), .halted(halted), .edge_status(edge_status),
    .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared),
    .wake_pulse(wake_pulse)
  );

  // bench copy of the wake masks stated in R6
  localparam logic [TW-1:0] WAKE_ALL = {32'h0012_007F, 32'hEC08_0000, 32'h0020_01FC, 32'h8003_FE1B};

  // {pin[6:0], is_out, rise, fall, halted, new_level}
  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {7'd0,   1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {7'd1,   1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {7'd2,   1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {7'd32,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {7'd37,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {7'd83,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {7'd99,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {7'd95,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {7'd3,   1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {7'd0,   1'b0, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_bank_we = '1;
    clr_data = '1;
    step();
    clr_bank_we = '0;
    clr_data = '0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R11 / R10: pins high with rising enables through reset
    pin_level = '1;
    rise_en = '1;
    repeat (3) step();
    check("R11 status in reset", edge_status, '0);
    check("R11 irq/wake in reset", TW'({irq_pin0, irq_pin1, irq_shared, wake_pulse}), '0);
    rst_n = 1'b1;
    halted = 1'b1;
    repeat (3) step();
    check("R10 no edge on first sample", edge_status, '0);
    check("R10 no wake on first sample", TW'(wake_pulse), '0);
    check("R10 irq quiet", TW'({irq_pin0, irq_pin1, irq_shared}), '0);
    rise_en = '0;
    halted = 1'b0;
    pin_level = '0;
    step();

    // table walk: R1 R2 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      int p;
      logic o, r, f, h, l, exp_set, exp_wake;
      logic [TW-1:0] exp_vec;
      {p, o, r, f, h, l} = {25'd0, VEC[i]};
      pin_is_out = '0; rise_en = '0; fall_en = '0; halted = 1'b0;
      pin_level = '0;
      pin_level[p] = ~l;
      repeat (2) step();
      clear_all();
      pin_is_out[p] = o; rise_en[p] = r; fall_en[p] = f; halted = h;
      step();
      pin_level[p] = l;
      step();
      exp_set = ~o & (l ? r : f);
      exp_wake = h & ~o & WAKE_ALL[p];
      exp_vec = '0;
      exp_vec[p] = exp_set;
      check(l ? "R1 rising status" : "R2 falling status", edge_status, exp_vec);
      check(o ? "R8 output pin no wake" : (exp_wake ? "R6 wake pulse" : "R7 no wake"),
            TW'(wake_pulse), TW'(exp_wake));
      step();
      check("R4 dedicated lines", TW'({irq_pin0, irq_pin1}),
            TW'({exp_set && p == 0, exp_set && p == 1}));
      check("R5 shared line", TW'(irq_shared), TW'(exp_set && p >= 2));
      check("R6 pulse is one cycle", TW'(wake_pulse), '0);
    end

    // R3: write-one-to-clear behaviour on pin 40 (bank 1 bit 8)
    pin_is_out = '0; rise_en = '0; fall_en = '0; halted = 1'b0; pin_level = '0;
    step();
    clear_all();
    rise_en[40] = 1'b1;
    step();
    pin_level[40] = 1'b1;
    step();
    check("R1 pin 40 set", TW'(edge_status[40]), TW'(1));
    clr_bank_we = 4'b0010; clr_data = '0;
    step();
    check("R3 zero data keeps bit", TW'(edge_status[40]), TW'(1));
    clr_bank_we = 4'b0001; clr_data = 32'h0000_0100;
    step();
    check("R3 other bank strobe keeps bit", TW'(edge_status[40]), TW'(1));
    clr_bank_we = 4'b0010;
    step();
    clr_bank_we = '0; clr_data = '0;
    check("R3 one clears bit", TW'(edge_status[40]), TW'(0));

    // R9: re-set the bit, then clear it while a falling edge arrives
    fall_en[40] = 1'b1;
    pin_level[40] = 1'b0;
    step();
    check("R2 pin 40 fall set", TW'(edge_status[40]), TW'(1));
    pin_level[40] = 1'b1;
    step();
    pin_level[40] = 1'b0;
    clr_bank_we = 4'b0010; clr_data = 32'h0000_0100;
    step();
    clr_bank_we = '0; clr_data = '0;
    check("R9 edge beats clear", TW'(edge_status[40]), TW'(1));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule